// File: doc/BRIEF.md
# Wide Register Chunk Shifter

This unit shifts a 256-bit register word left or right as one value. The shift moves whole units, so data crosses the 64-bit chunk boundaries. The unit size is chosen per operation from 8, 16, 32 or 64 bits. The distance is the unit size multiplied by a count taken from a separate 64-bit count operand. Vacated positions fill with zeros, and there is no rotate and no sign extension. Any distance of 256 bits or more gives an all-zero word.

An operation is presented with a valid strobe. The result and its valid flag come back registered one clock later. A logarithmic chain of byte-granular stages forms the shift. This works because every legal distance is a whole number of bytes.

Top module: `wide_chunk_shifter`

## Requirements
- R1: With `dir_right` = 0 the captured result equals `src` shifted left by (unit × count) bits, with zeros entering at bit 0.
- R2: With `dir_right` = 1 the captured result equals `src` shifted right by (unit × count) bits, with zeros entering at bit 255.
- R3: `unit_sel` selects the unit size: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = 64 bits.
- R4: When unit × count is 256 or greater, the result is all zeros in either direction.
- R5: The count is `cnt[7:0]`. If any bit of `cnt[63:8]` is 1, the result is all zeros whatever the low byte holds.
- R6: A count of zero returns `src` unchanged in either direction and for every unit size.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` takes its new value at that same clock edge.
- R8: While `in_valid` is low, `result` holds its last value and ignores `src`, `cnt`, `dir_right` and `unit_sel`.
- R9: An active-low `rst_n` clears `out_valid` and `result` to zero at once, without waiting for a clock edge.
- R10: The shift acts on all 256 bits as one value with no per-chunk partitioning. For example, a left shift of one 64-bit unit moves chunk 0 into chunk 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; the operands are captured on this edge |
| src | input | 256 | Source register word |
| cnt | input | 64 | Count operand; the low byte is the count |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| unit_sel | input | 2 | Unit size select (see R3) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 256 | Shifted word |

## Verification
Two zero-forcing paths can fire on the same operation. One is the forcing from the high count bits. The other is the range overflow from the scaled low byte. The bench provokes the interesting overlaps on purpose. Some vectors set a high count bit while the low byte holds a small, in-range count. Others set a high bit together with a low byte that already overflows on its own. In both cases the result must be exactly zero. Boundary vectors sit one unit below and exactly at the 256-bit limit for each unit size. They check that the range test neither clips a legal last-unit shift nor lets through a distance of a full register.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int CHUNK_W = 64;

  typedef enum logic [1:0] {
    UNIT_B8  = 2'b00,
    UNIT_B16 = 2'b01,
    UNIT_B32 = 2'b10,
    UNIT_B64 = 2'b11
  } unit_e;
endpackage

// File: rtl/wcs_amount_decode.sv
module wcs_amount_decode
  import wcs_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NBYTES = 32,
  parameter int STG    = 5
) (
  input  logic [CNT_W-1:0] cnt_lo,
  input  logic             cnt_hi_any,
  input  unit_e            unit,
  output logic [STG-1:0]   byte_amt,
  output logic             zero_force
);
  // The count is scaled to bytes: the unit in bytes is 1 << unit.
  localparam int BW = CNT_W + 3;
  localparam logic [BW-1:0] LIMIT = BW'(NBYTES);

  logic [BW-1:0] byte_full;

  always_comb begin
    byte_full  = {3'b000, cnt_lo} << unit;
    byte_amt   = byte_full[STG-1:0];
    zero_force = cnt_hi_any | (byte_full >= LIMIT);
  end
endmodule

// File: rtl/wcs_barrel_stage.sv
module wcs_barrel_stage #(
  parameter int W  = 256,
  parameter int SH = 8
) (
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic         right,
  output logic [W-1:0] q
);
  always_comb begin
    if (!en)
      q = d;
    else if (right)
      q = d >> SH;
    else
      q = d << SH;
  end
endmodule

// File: rtl/wide_chunk_shifter.sv
module wide_chunk_shifter
  import wcs_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int OPND_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src,
  input  logic [OPND_W-1:0] cnt,
  input  logic              dir_right,
  input  logic [1:0]        unit_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NBYTES = DATA_W / 8;
  localparam int STG    = $clog2(NBYTES);

  logic [STG-1:0]    byte_amt;
  logic              zero_force;
  logic [DATA_W-1:0] chain [STG+1];

  logic [DATA_W-1:0] result_d, result_q;
  logic              valid_d, valid_q;

  wcs_amount_decode #(
    .CNT_W (CNT_W),
    .NBYTES(NBYTES),
    .STG   (STG)
  ) u_dec (
    .cnt_lo    (cnt[CNT_W-1:0]),
    .cnt_hi_any(|cnt[OPND_W-1:CNT_W]),
    .unit      (unit_e'(unit_sel)),
    .byte_amt  (byte_amt),
    .zero_force(zero_force)
  );

  assign chain[0] = src;

  generate
    for (genvar g = 0; g < STG; g++) begin : g_stage
      wcs_barrel_stage #(
        .W (DATA_W),
        .SH(8 << g)
      ) u_stage (
        .d    (chain[g]),
        .en   (byte_amt[g]),
        .right(dir_right),
        .q    (chain[g+1])
      );
    end
  endgenerate

  // Next-state logic
  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    if (in_valid)
      result_d = zero_force ? '0 : chain[STG];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
  parameter int DATA_W = 256,
  parameter int OPND_W = 64,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] src,
  input logic [OPND_W-1:0] cnt,
  input logic              dir_right,
  input logic [1:0]        unit_sel,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_high_bits_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|cnt[OPND_W-1:CNT_W])) |=> (result == '0));

  p_full_width_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unit_sel == 2'b11 && cnt[CNT_W-1:0] >= 4) |=> (result == '0));

  p_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt == '0) |=> (result == $past(src)));

  p_left_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dir_right && unit_sel == 2'b11 && cnt == 1) |=> (result[63:0] == '0));

  p_right_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dir_right && unit_sel == 2'b11 && cnt == 1)
      |=> (result[DATA_W-1:DATA_W-64] == '0));
endmodule

bind wide_chunk_shifter wcs_checker #(
  .DATA_W(DATA_W),
  .OPND_W(OPND_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .src      (src),
  .cnt      (cnt),
  .dir_right(dir_right),
  .unit_sel (unit_sel),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/wide_chunk_shifter_tb.sv
module wide_chunk_shifter_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [255:0] src;
  logic [63:0]  cnt;
  logic         dir_right;
  logic [1:0]   unit_sel;
  logic         out_valid;
  logic [255:0] result;

  int n_vec  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  wide_chunk_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .cnt(cnt),
    .dir_right(dir_right), .unit_sel(unit_sel), .out_valid(out_valid), .result(result)
  );

  // Vector fields: [68] dir, [67:66] unit, [65:64] source id, [63:0] count
  localparam int NV = 20;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 2'd3, 2'd1, 64'd1},    // R10 chunk0 -> chunk1
    {1'b0, 2'd3, 2'd1, 64'd3},    // R1 to top chunk
    {1'b0, 2'd3, 2'd1, 64'd4},    // R4 exactly 256
    {1'b1, 2'd3, 2'd2, 64'd1},    // R2
    {1'b1, 2'd3, 2'd2, 64'd3},    // R2 top -> chunk0
    {1'b1, 2'd3, 2'd3, 64'd255},  // R4
    {1'b0, 2'd0, 2'd0, 64'd1},    // R3 byte unit
    {1'b0, 2'd0, 2'd3, 64'd31},   // R4 last legal byte
    {1'b0, 2'd0, 2'd3, 64'd32},   // R4 byte limit
    {1'b1, 2'd1, 2'd0, 64'd5},    // R3 16-bit
    {1'b1, 2'd1, 2'd3, 64'd15},   // R4 last legal half
    {1'b1, 2'd1, 2'd3, 64'd16},   // R4 half limit
    {1'b0, 2'd2, 2'd3, 64'd7},    // R3 32-bit
    {1'b0, 2'd2, 2'd3, 64'd8},    // R4 word limit
    {1'b1, 2'd2, 2'd0, 64'd3},    // R3 crosses chunks
    {1'b0, 2'd3, 2'd0, 64'd0},    // R6
    {1'b1, 2'd0, 2'd2, 64'd0},    // R6
    {1'b0, 2'd3, 2'd3, 64'h100},  // R5 high bit, low byte zero
    {1'b1, 2'd0, 2'd0, 64'h8000_0000_0000_0001}, // R5 with small low count
    {1'b0, 2'd0, 2'd3, 64'h0000_0001_0000_0040}  // R5 with overflowing low count
  };

  function automatic logic [255:0] pat(input logic [1:0] id);
    case (id)
      2'd0:    pat = {4{64'h0123_4567_89AB_CDEF}};
      2'd1:    pat = {192'd0, 64'hFEDC_BA98_7654_3210};
      2'd2:    pat = {64'h8000_0000_0000_0001, 192'd0};
      default: pat = {256{1'b1}};
    endcase
  endfunction

  function automatic logic [255:0] model(input logic d, input logic [1:0] u,
                                         input logic [255:0] s, input logic [63:0] c);
    int amt;
    amt = int'(c[7:0]) * (8 << u);
    if (|c[63:8] || amt >= 256) model = '0;
    else if (d)                 model = s >> amt;
    else                        model = s << amt;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic d, input logic [1:0] u, input logic [255:0] s,
                       input logic [63:0] c);
    @(negedge clk);
    in_valid = 1'b1; dir_right = d; unit_sel = u; src = s; cnt = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    logic [255:0] exp;
    string tag;
    rst_n = 1'b0; in_valid = 1'b0; src = '0; cnt = '0; dir_right = 1'b0; unit_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {255'd0, out_valid}, 256'd0);
    check("R9 reset result", result, 256'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][68], VEC[i][67:66], pat(VEC[i][65:64]), VEC[i][63:0]);
      exp = model(VEC[i][68], VEC[i][67:66], pat(VEC[i][65:64]), VEC[i][63:0]);
      if (|VEC[i][63:8])                 tag = "R5";
      else if (VEC[i][63:0] == 64'd0)    tag = "R6";
      else if (exp == '0)                tag = "R4";
      else if (VEC[i][68])               tag = "R2 R3 R10";
      else                               tag = "R1 R3 R10";
      check("R7 valid", {255'd0, out_valid}, 256'd1);
      check(tag, result, exp);
    end

    // R10: chunk 0 moves into chunk 1
    apply(1'b0, 2'b11, {192'd0, 64'hAAAA_5555_1234_5678}, 64'd1);
    check("R10 chunk move", result, {128'd0, 64'hAAAA_5555_1234_5678, 64'd0});

    // R8: idle cycles with changing operands leave result alone
    exp = result;
    src = ~src; cnt = 64'd2; dir_right = 1'b1; unit_sel = 2'b00;
    repeat (3) @(negedge clk);
    check("R8 hold", result, exp);
    check("R7 idle valid", {255'd0, out_valid}, 256'd0);

    // R9: asynchronous reset mid-run
    apply(1'b0, 2'b00, pat(2'd3), 64'd1);
    check("R7 valid before reset", {255'd0, out_valid}, 256'd1);
    #1 rst_n = 1'b0;
    #1;
    check("R9 async valid", {255'd0, out_valid}, 256'd0);
    check("R9 async result", result, 256'd0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 2'b11, pat(2'd2), 64'd2);
    check("R2 after reset", result, model(1'b1, 2'b11, pat(2'd2), 64'd2));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule